// File: doc/BRIEF.md
# SMBus Configuration Register Target

This block is a byte-oriented SMBus target that lets a host reach a small register file of control and status bytes. A fast system clock samples the serial clock and data lines through two-flop synchronisers. START, repeated START and STOP conditions are found on the synchronised lines, and a protocol engine walks through the address, pointer and data bytes. The SDA line is modelled as an input plus an open-drain pull-down enable. The top module has no pads.

A host reaches the block only while the chip-select input is high. Two transactions are supported: a single-register write (address, pointer, data), and a random-address read (address, pointer, repeated START, address with read bit, one data byte). Pointer values 3 to 8 hold six read/write control bytes, and all six are presented in parallel to downstream logic. Pointer values 0 to 2 hold three read-only status bytes built from live inputs. A transfer is abandoned if SCL stays low too long, or if both lines stay high too long in the middle of a transfer.

Top module: `smbus_cfg_target`

## Requirements
- R1: The block answers only the 7-bit address 1010110 (0x56), so the write address byte is 0xAC and the read address byte is 0xAD. On a match it acknowledges by pulling SDA low for the 9th clock. On any other address it gives no acknowledge and ignores the bus until the next START.
- R2: While chip select is low, the block never asserts the SDA pull-down, and bus traffic changes no register.
- R3: START (SDA falling while SCL is high) restarts address reception at any point, including in the middle of a byte. STOP (SDA rising while SCL is high) ends the transfer. Both release SDA, and data clocked after a STOP without a new START is not acknowledged.
- R4: A write is START, 0xAC, pointer byte, data byte, STOP, with each byte acknowledged. The data byte reaches the addressed control register at its acknowledge.
- R5: A read is START, 0xAC, pointer byte, repeated START, 0xAD, followed by eight data bits sent MSB first. The block releases SDA after the 8th bit, and the host's acknowledge bit has no effect.
- R6: After reset, control registers 3 and 4 read 0x77, registers 5, 6 and 7 read 0x00, and register 8 reads 0x78. ctrl_o carries register 3 in bits 7:0, register 4 in bits 15:8, and so on up to register 8 in bits 47:40.
- R7: Pointer values 0 to 2 are read-only status. Register 0 is {status_i[6:0], sigdet_i}, with bit 0 following sigdet_i live. Register 1 is status_i[14:7] and register 2 is status_i[22:15]. The pointer byte is always acknowledged. A data byte aimed at pointer 0 to 2 or 9 to 255 gets no acknowledge and changes no register.
- R8: Reads of pointer values 9 to 255 return 0x00.
- R9: If SCL stays low for TIMEOUT_CYC system clocks during a transfer, the transfer is abandoned, and later clocks get no acknowledge until a new START.
- R10: If SCL and SDA both stay high for IDLE_CYC system clocks during a transfer, the transfer is abandoned in the same way.
- R11: The SDA pull-down is only switched on while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select; the bus is heard only while high |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| sigdet_i | input | 1 | Live signal-detect status, bit 0 of register 0 |
| status_i | input | 23 | Remaining status bits for registers 0 to 2 |
| ctrl_o | output | 48 | Control registers 3 to 8, packed |

## Verification
Every decision the block makes follows an SCL edge at the pins. Such an edge reaches the synchronised copy two system clocks later, and the registered result (the SDA pull-down, a register write on ctrl_o, a new data bit) appears on the third clock edge. The bench holds each SCL phase for 12 system clocks. It reads SDA in the middle of the high phase, well after the pull-down has settled, and it checks ctrl_o only after the STOP, so no check depends on the exact edge. Timeout cases hold a line for the limit plus 20 clocks, and then the bench looks for the acknowledge that would have followed if the transfer had survived.

// File: rtl/smbt_pkg.sv
package smbt_pkg;
  localparam int BYTE_W    = 8;
  localparam int N_STAT    = 3;
  localparam int N_CTRL    = 6;
  localparam int CTRL_BASE = 3;
  localparam int CTRL_W    = N_CTRL * BYTE_W;
  localparam int STAT_IN_W = N_STAT * BYTE_W - 1;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 48'h78_00_00_00_77_77;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_REG, ST_ACK_R,
    ST_DATA, ST_ACK_D, ST_TX, ST_WAIT
  } smbt_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } smbt_evt_t;
endpackage

// File: rtl/smbt_line_sync.sv
module smbt_line_sync
  import smbt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cs_i,
  input  logic      scl_i,
  input  logic      sda_i,
  output logic      cs_s,
  output logic      scl_s,
  output logic      sda_s,
  output smbt_evt_t evt
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_sh, sda_sh, cs_sh;
  logic         scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      cs_sh  <= '0;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[MSB-1:0], scl_i};
      sda_sh <= {sda_sh[MSB-1:0], sda_i};
      cs_sh  <= {cs_sh[MSB-1:0], cs_i};
      scl_d  <= scl_sh[MSB];
      sda_d  <= sda_sh[MSB];
    end
  end

  assign cs_s  = cs_sh[MSB];
  assign scl_s = scl_sh[MSB];
  assign sda_s = sda_sh[MSB];

  // Conditions need a stable-high clock across two samples; all gated by select
  always_comb begin
    evt.start = cs_s & scl_s & scl_d &  sda_d & ~sda_s;
    evt.stop  = cs_s & scl_s & scl_d & ~sda_d &  sda_s;
    evt.rise  = cs_s &  scl_s & ~scl_d;
    evt.fall  = cs_s & ~scl_s &  scl_d;
  end
endmodule

// File: rtl/smbt_regs.sv
module smbt_regs
  import smbt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BYTE_W-1:0]    ptr,
  input  logic                 wr_en,
  input  logic [BYTE_W-1:0]    wr_data,
  input  logic                 sigdet_i,
  input  logic [STAT_IN_W-1:0] status_i,
  output logic [BYTE_W-1:0]    rd_data,
  output logic                 wr_allow,
  output logic [CTRL_W-1:0]    ctrl_o
);
  localparam logic [BYTE_W-1:0] LO = BYTE_W'(CTRL_BASE);
  localparam logic [BYTE_W-1:0] HI = BYTE_W'(CTRL_BASE + N_CTRL - 1);

  logic [N_STAT*BYTE_W-1:0] stat_all;
  logic [CTRL_W-1:0]        ctrl_q;

  assign stat_all = {status_i, sigdet_i};
  assign wr_allow = (ptr >= LO) && (ptr <= HI);

  for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
    localparam logic [BYTE_W-1:0] SEL = BYTE_W'(CTRL_BASE + g);
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     q <= CTRL_RESET[g*BYTE_W +: BYTE_W];
      else if (wr_en && (ptr == SEL)) q <= wr_data;
    end
    assign ctrl_q[g*BYTE_W +: BYTE_W] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < N_STAT; k++)
      if (ptr == BYTE_W'(k)) rd_data = stat_all[k*BYTE_W +: BYTE_W];
    for (int k = 0; k < N_CTRL; k++)
      if (ptr == BYTE_W'(CTRL_BASE + k)) rd_data = ctrl_q[k*BYTE_W +: BYTE_W];
  end

  assign ctrl_o = ctrl_q;

  // R7: the protocol engine only commits to the read/write window
  a_r7_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((ptr >= LO) && (ptr <= HI)));
endmodule

// File: rtl/smbt_engine.sv
module smbt_engine
  import smbt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h56,
  parameter int         TIMEOUT_CYC = 5_000_000,
  parameter int         IDLE_CYC    = 10_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              scl_s,
  input  logic              sda_s,
  input  smbt_evt_t         evt,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic              wr_allow,
  output logic [BYTE_W-1:0] ptr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);
  localparam int ID_W  = $clog2(IDLE_CYC + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  smbt_state_e       st, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [BYTE_W-1:0] sh, sh_n, ptr_n;
  logic              rw, rw_n, oe_n;
  logic [TO_W-1:0]   lowcnt, lowcnt_n;
  logic [ID_W-1:0]   hicnt, hicnt_n;
  logic              busy, low_cond, hi_cond, abandon, rx_state;

  assign busy     = (st != ST_IDLE);
  assign low_cond = busy && !scl_s;
  assign hi_cond  = busy && scl_s && sda_s;
  assign abandon  = (low_cond && (lowcnt == TO_W'(TIMEOUT_CYC - 1))) ||
                    (hi_cond  && (hicnt  == ID_W'(IDLE_CYC - 1)));
  assign rx_state = (st == ST_ADDR) || (st == ST_REG) || (st == ST_DATA);
  assign lowcnt_n = low_cond ? lowcnt + 1'b1 : '0;
  assign hicnt_n  = hi_cond  ? hicnt  + 1'b1 : '0;
  assign wr_data  = sh;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    sh_n  = sh;
    ptr_n = ptr;
    rw_n  = rw;
    oe_n  = sda_oe;
    wr_en = 1'b0;
    if (!cs_s) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (evt.start) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (evt.stop || abandon) begin
      st_n  = ST_IDLE;
      oe_n  = 1'b0;
    end else if (evt.rise) begin
      if (rx_state && cnt != FULL) begin
        sh_n  = {sh[BYTE_W-2:0], sda_s};
        cnt_n = cnt + 1'b1;
      end else if (st == ST_TX && cnt != FULL) begin
        cnt_n = cnt + 1'b1;
      end
    end else if (evt.fall) begin
      unique case (st)
        ST_ADDR: if (cnt == FULL) begin
          cnt_n = '0;
          if (sh[BYTE_W-1:1] == DEV_ADDR) begin
            rw_n = sh[0];
            st_n = ST_ACK_A;
            oe_n = 1'b1;
          end else st_n = ST_WAIT;
        end
        ST_REG: if (cnt == FULL) begin
          cnt_n = '0;
          ptr_n = sh;
          st_n  = ST_ACK_R;
          oe_n  = 1'b1;
        end
        ST_DATA: if (cnt == FULL) begin
          cnt_n = '0;
          if (wr_allow) begin
            wr_en = 1'b1;
            st_n  = ST_ACK_D;
            oe_n  = 1'b1;
          end else st_n = ST_WAIT;
        end
        ST_ACK_A: if (rw) begin
          st_n = ST_TX;
          sh_n = rd_data;
          oe_n = ~rd_data[BYTE_W-1];
        end else begin
          st_n = ST_REG;
          oe_n = 1'b0;
        end
        ST_ACK_R: begin st_n = ST_DATA; oe_n = 1'b0; end
        ST_ACK_D: begin st_n = ST_WAIT; oe_n = 1'b0; end
        ST_TX: if (cnt == FULL) begin
          st_n = ST_WAIT;
          oe_n = 1'b0;
        end else begin
          sh_n = {sh[BYTE_W-2:0], 1'b0};
          oe_n = ~sh[BYTE_W-2];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      sda_oe <= 1'b0;
      lowcnt <= '0;
      hicnt  <= '0;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      sh     <= sh_n;
      ptr    <= ptr_n;
      rw     <= rw_n;
      sda_oe <= oe_n;
      lowcnt <= lowcnt_n;
      hicnt  <= hicnt_n;
    end
  end

  // R11: pull-down only switched on while the synchronised clock is low
  a_r11_drive_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  // R3: a START releases the data line
  a_r3_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    evt.start |=> !sda_oe);
  // R3: a STOP releases the data line
  a_r3_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    evt.stop |=> !sda_oe);
  // R4: every committed write is acknowledged
  a_r4_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_oe);
endmodule

// File: rtl/smbus_cfg_target.sv
module smbus_cfg_target
  import smbt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h56,
  parameter int         TIMEOUT_CYC = 5_000_000,
  parameter int         IDLE_CYC    = 10_000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_i,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  input  logic                 sigdet_i,
  input  logic [STAT_IN_W-1:0] status_i,
  output logic [CTRL_W-1:0]    ctrl_o
);
  logic              cs_s, scl_s, sda_s, wr_en, wr_allow;
  logic [BYTE_W-1:0] ptr, wr_data, rd_data;
  smbt_evt_t         evt;

  smbt_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .scl_i(scl_i), .sda_i(sda_i),
    .cs_s(cs_s), .scl_s(scl_s), .sda_s(sda_s), .evt(evt)
  );

  smbt_engine #(
    .DEV_ADDR(DEV_ADDR), .TIMEOUT_CYC(TIMEOUT_CYC), .IDLE_CYC(IDLE_CYC)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .scl_s(scl_s), .sda_s(sda_s),
    .evt(evt), .rd_data(rd_data), .wr_allow(wr_allow), .ptr(ptr),
    .wr_en(wr_en), .wr_data(wr_data), .sda_oe(sda_oe_o)
  );

  smbt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
    .sigdet_i(sigdet_i), .status_i(status_i), .rd_data(rd_data),
    .wr_allow(wr_allow), .ctrl_o(ctrl_o)
  );

  // R2: a deselected target lets go of the data line
  a_r2_deselect_release: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !sda_oe_o);
endmodule

// File: tb/smbus_cfg_target_test.sv
`timescale 1ns/1ps
module smbus_cfg_target_test;
  localparam int H   = 12;
  localparam int TO  = 100;
  localparam int IDL = 60;

  logic        clk = 1'b0;
  logic        rst_n, cs, scl_h, sda_h, sigdet;
  logic [22:0] status;
  logic        sda_oe;
  logic [47:0] ctrl;
  wire         sda_line = sda_h & ~sda_oe;

  int n_chk = 0;
  int n_err = 0;
  int viol  = 0;
  int rises = 0;
  int oe_cnt = 0;
  logic oe_prev = 1'b0;
  logic [7:0] exp_ctrl [6];

  always #2.5 clk = ~clk;

  smbus_cfg_target #(.TIMEOUT_CYC(TO), .IDLE_CYC(IDL)) uut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .scl_i(scl_h), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .sigdet_i(sigdet), .status_i(status), .ctrl_o(ctrl)
  );

  // R11 monitor: pull-down must never switch on while SCL is high
  always @(negedge clk) begin
    if (sda_oe && !oe_prev) begin
      rises++;
      if (scl_h) viol++;
    end
    if (sda_oe) oe_cnt++;
    oe_prev = sda_oe;
  end

  task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hold(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    sda_h = 1'b1; hold(H); scl_h = 1'b1; hold(H);
    sda_h = 1'b0; hold(H); scl_h = 1'b0; hold(H);
  endtask

  task automatic bus_stop;
    sda_h = 1'b0; hold(H); scl_h = 1'b1; hold(H); sda_h = 1'b1; hold(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_h = b[7-i]; hold(H); scl_h = 1'b1; hold(H); scl_h = 1'b0; hold(2);
    end
  endtask

  task automatic ack_clock(output logic acked);
    sda_h = 1'b1; hold(H); scl_h = 1'b1; hold(H/2);
    acked = ~sda_line; hold(H/2); scl_h = 1'b0; hold(2);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    logic dummy;
    sda_h = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hold(H); scl_h = 1'b1; hold(H/2); b = {b[6:0], sda_line};
      hold(H/2); scl_h = 1'b0; hold(2);
    end
    ack_clock(dummy);
  endtask

  task automatic do_write(input logic [7:0] r, input logic [7:0] d,
                          output logic [2:0] acks);
    bus_start;
    send_bits(8'hAC, 8); ack_clock(acks[2]);
    send_bits(r, 8);     ack_clock(acks[1]);
    send_bits(d, 8);     ack_clock(acks[0]);
    bus_stop;
  endtask

  task automatic do_read(input logic [7:0] r, output logic [7:0] d,
                         output logic [2:0] acks);
    bus_start;
    send_bits(8'hAC, 8); ack_clock(acks[2]);
    send_bits(r, 8);     ack_clock(acks[1]);
    bus_start;
    send_bits(8'hAD, 8); ack_clock(acks[0]);
    recv_byte(d);
    bus_stop;
  endtask

  function automatic logic [47:0] exp_pack();
    logic [47:0] v;
    for (int k = 0; k < 6; k++) v[k*8 +: 8] = exp_ctrl[k];
    return v;
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] r);
    if (r == 8'd0) return {status[6:0], sigdet};
    if (r == 8'd1) return status[14:7];
    if (r == 8'd2) return status[22:15];
    if (r >= 8'd3 && r <= 8'd8) return exp_ctrl[r-3];
    return 8'h00;
  endfunction

  task automatic finish_run;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run;
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] rd;
    logic       ak;
    rst_n = 1'b0; cs = 1'b1; scl_h = 1'b1; sda_h = 1'b1;
    sigdet = 1'b1; status = 23'h5A3C1;
    exp_ctrl[0] = 8'h77; exp_ctrl[1] = 8'h77; exp_ctrl[2] = 8'h00;
    exp_ctrl[3] = 8'h00; exp_ctrl[4] = 8'h00; exp_ctrl[5] = 8'h78;
    hold(5); rst_n = 1'b1; hold(5);

    // R6 reset values
    check("R6 reset ctrl_o", ctrl, 48'h78_00_00_00_77_77);
    check("R6 reset sda_oe", {47'd0, sda_oe}, 48'd0);

    // R1 sweep of every 7-bit address with write bit
    for (int a = 0; a < 128; a++) begin
      bus_start;
      send_bits({a[6:0], 1'b0}, 8);
      ack_clock(ak);
      bus_stop;
      check($sformatf("R1 ack addr %0h", a), {47'd0, ak}, {47'd0, (a == 'h56)});
    end

    // R4 / R7 write sweep
    for (int i = 0; i < 17; i++) begin
      logic [7:0] r, d;
      r = (i == 16) ? 8'hFF : 8'(i);
      d = 8'(i * 29 + 7);
      do_write(r, d, acks);
      if (r >= 3 && r <= 8) exp_ctrl[r-3] = d;
      check($sformatf("R4 R7 acks ptr %0h", r), {45'd0, acks},
            {45'd0, 1'b1, 1'b1, (r >= 3 && r <= 8)});
      check($sformatf("R4 R7 ctrl_o after ptr %0h", r), ctrl, exp_pack());
    end

    // R5 / R7 / R8 read sweep
    for (int i = 0; i < 17; i++) begin
      logic [7:0] r;
      r = (i == 16) ? 8'hFF : 8'(i);
      do_read(r, rd, acks);
      check($sformatf("R5 acks ptr %0h", r), {45'd0, acks}, {45'd0, 3'b111});
      check($sformatf("R5 R7 R8 data ptr %0h", r), {40'd0, rd}, {40'd0, exp_read(r)});
    end

    // R7 live signal-detect bit
    sigdet = 1'b0; status = 23'h12345; hold(4);
    do_read(8'd0, rd, acks);
    check("R7 reg0 sigdet low", {40'd0, rd}, {40'd0, exp_read(8'd0)});
    sigdet = 1'b1; hold(4);
    do_read(8'd0, rd, acks);
    check("R7 reg0 sigdet high", {40'd0, rd}, {40'd0, exp_read(8'd0)});

    // R2 chip select low
    cs = 1'b0; hold(5); oe_cnt = 0;
    do_write(8'd5, 8'hEE, acks);
    check("R2 no acks deselected", {45'd0, acks}, 48'd0);
    check("R2 no pull-down deselected", 48'(oe_cnt), 48'd0);
    check("R2 ctrl_o unchanged", ctrl, exp_pack());
    cs = 1'b1; hold(5);

    // R3 START in the middle of a byte restarts address reception
    bus_start;
    send_bits(8'hFF, 4);
    bus_start;
    send_bits(8'hAC, 8); ack_clock(acks[2]);
    send_bits(8'd6, 8);  ack_clock(acks[1]);
    send_bits(8'h5C, 8); ack_clock(acks[0]);
    bus_stop;
    exp_ctrl[3] = 8'h5C;
    check("R3 restart acks", {45'd0, acks}, {45'd0, 3'b111});
    check("R3 restart write", ctrl, exp_pack());

    // R3 data after STOP without START is ignored
    bus_start;
    send_bits(8'hAC, 8); ack_clock(ak);
    send_bits(8'd7, 8);  ack_clock(ak);
    bus_stop;
    scl_h = 1'b0; hold(H);
    send_bits(8'h11, 8); ack_clock(ak);
    bus_stop;
    check("R3 no ack after stop", {47'd0, ak}, 48'd0);
    check("R3 reg7 unchanged after stop", ctrl, exp_pack());

    // R9 SCL held low abandons the transfer
    bus_start;
    send_bits(8'hAC, 7);
    hold(TO + 20);
    send_bits(8'h00, 1);
    ack_clock(ak);
    bus_stop;
    check("R9 no ack after low timeout", {47'd0, ak}, 48'd0);

    // R10 both lines high abandons the transfer
    bus_start;
    send_bits(8'hAC, 7);
    sda_h = 1'b1; hold(H); scl_h = 1'b1; hold(IDL + 20);
    scl_h = 1'b0; hold(2);
    ack_clock(ak);
    bus_stop;
    check("R10 no ack after high idle", {47'd0, ak}, 48'd0);

    // Bus still usable afterwards
    do_read(8'd6, rd, acks);
    check("R5 read after timeouts", {37'd0, acks, rd}, {37'd0, 3'b111, exp_read(8'd6)});

    // R11 summary of the monitor
    check("R11 pull-down rises seen", {47'd0, rises > 0}, 48'd1);
    check("R11 rises while SCL high", 48'(viol), 48'd0);

    finish_run;
  end
endmodule